// File: doc/BRIEF.md
# Countdown Watchdog with Flagged Interrupt

A software watchdog driven by a slow periodic tick (nominally 32 Hz, supplied as a one-cycle strobe from a timekeeping divider). Software writes a 6-bit reload value. The counter loads it and counts down one step per tick. When the count runs out, a timeout event fires: a sticky flag is set, and the counter restarts from the reload value. A reload value of zero stops the countdown, so the watchdog is disabled.

The flag is cleared by reading the flag register. A control register chooses whether a pending flag drives the interrupt pin, which level the pin uses when active, and whether a timeout also issues a one-cycle reset-request pulse. Software services the watchdog by writing the reload register again before the count runs out. All register accesses are single-cycle. Read data is combinational from the current state.

Top module: `cntdn_wdog`

## Requirements
- R1: After reset the flag, control and reload registers read 0x00, `irq_o` is 1 (inactive at the default active-low level) and `rst_req_o` is 0.
- R2: Writing address 2 stores bits 5:0 of the write data as the reload value and loads the counter with it. Reading address 2 returns the reload value in bits 5:0, with bits 7:6 as zero.
- R3: With reload value N (1..63), the flag is set at the clock edge of the N-th tick after the reload write, and not before. A tick is a cycle with `tick_i` = 1.
- R4: After a timeout the counter restarts from the reload value, and the next timeout comes after another N ticks.
- R5: Writing the reload register restarts the countdown. If the write and a tick happen in the same cycle, the write takes effect and the tick is not counted.
- R6: With a reload value of 0, no number of ticks sets the flag.
- R7: Address 0 returns the flag in bit 7, with all other bits zero. A read of address 0 clears the flag at that clock edge.
- R8: If a timeout and a read of address 0 happen in the same cycle, the flag stays set.
- R9: Control bit 0 enables the interrupt and control bit 1 selects its polarity (1 = active high). `irq_o` is at its active level exactly while the flag is set and bit 0 is 1; otherwise it is at the inactive level.
- R10: When control bit 2 is 1, each timeout drives `rst_req_o` high for the cycle after the timeout edge.
- R11: Address 1 reads back control bits 2:0, with bits 7:3 as zero. Address 3 always reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one count per high cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears the flag at address 0) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address |
| irq_o | output | 1 | Interrupt, polarity set by software |
| rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
Directed sequences cover several cases. Counts of exactly N-1 and N ticks separate an off-by-one in the compare. Back-to-back periods show the automatic restart. A reload write that lands on a tick checks that the write takes priority. A read that lands on a timeout checks that the set beats the clear. A long run of ticks with a zero reload confirms the disable. Constrained-random traffic mixes short reload values, dense ticks, control changes and reads at random addresses. It is compared cycle by cycle against a bench model, so ordering interactions between writes, reads and ticks show up as data or pin mismatches. Polarity cases hold the flag fixed while the control bits change, which separates the enable gating from the level selection.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned CTRL_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAGS  = 2'd0,
    A_CTRL   = 2'd1,
    A_RELOAD = 2'd2,
    A_SPARE  = 2'd3
  } wdog_addr_e;

  typedef struct packed {
    logic rst_en;
    logic pol_hi;
    logic irq_en;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              expire_i,
  output wdog_ctrl_t        ctrl_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o
);
  logic [CNT_W-1:0] reload_q;
  wdog_ctrl_t       ctrl_q;
  logic             flag_q;
  logic             wdata_unused;

  assign wdata_unused = ^wdata_i[DATA_W-1:CNT_W];
  assign load_o       = we_i && (addr_i == A_RELOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (load_o) reload_q <= wdata_i[CNT_W-1:0];
      if (we_i && (addr_i == A_CTRL)) ctrl_q <= wdata_i[CTRL_W-1:0];
      // set wins over read-clear
      if (expire_i) flag_q <= 1'b1;
      else if (re_i && (addr_i == A_FLAGS)) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_FLAGS:  rdata_o[FLAG_BIT]       = flag_q;
      A_CTRL:   rdata_o[CTRL_W-1:0]     = ctrl_q;
      A_RELOAD: rdata_o[CNT_W-1:0]      = reload_q;
      default:  rdata_o                 = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // zero count means disabled; a write takes priority over a tick
  assign expire_o = tick_i && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= (cnt_q == ONE) ? reload_i : cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       flag_i,
  input  wdog_ctrl_t ctrl_i,
  output logic       irq_o,
  output logic       rst_req_o
);
  logic pend;
  logic rst_req_q;

  assign pend  = flag_i && ctrl_i.irq_en;
  assign irq_o = ctrl_i.pol_hi ? pend : !pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= expire_i && ctrl_i.rst_en;
  end

  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/cntdn_wdog.sv
module cntdn_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  wdog_ctrl_t       ctrl;
  logic             flag;
  logic             expire;
  logic             load;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .re_i     (reg_re_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .expire_i (expire),
    .ctrl_o   (ctrl),
    .flag_o   (flag),
    .reload_o (reload),
    .load_o   (load)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (reg_wdata_i[CNT_W-1:0]),
    .reload_i   (reload),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  wdog_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .flag_i    (flag),
    .ctrl_i    (ctrl),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              expire,
  input logic              flag,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input wdog_ctrl_t        ctrl
);
  // R3
  expire_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |-> tick_i);

  // R3
  expire_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag);

  // R4
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= reload);

  // R5
  reload_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_RELOAD) |=> (cnt == $past(reg_wdata_i[CNT_W-1:0])));

  // R6
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload == '0) |-> !expire);

  // R7
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == A_FLAGS && !expire) |=> !flag);

  // R9
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.irq_en |-> (irq_o == !ctrl.pol_hi));

  // R10
  rst_req_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> flag);
endmodule

bind cntdn_wdog wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .rst_req_o   (rst_req_o),
  .expire      (expire),
  .flag        (flag),
  .cnt         (cnt),
  .reload      (reload),
  .ctrl        (ctrl)
);

// File: tb/test_cntdn_wdog.sv
module test_cntdn_wdog;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_re_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;
  logic       rst_req_o;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  // bench model
  logic [5:0] m_cnt = '0;
  logic [5:0] m_rel = '0;
  logic       m_flag = 1'b0;
  logic [2:0] m_ctrl = '0;
  logic       m_rstp = 1'b0;
  logic [7:0] last_rd = '0;

  cntdn_wdog i_cntdn_wdog (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {m_flag, 7'd0};
      2'd1:    return {5'd0, m_ctrl};
      2'd2:    return {2'd0, m_rel};
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic pend;
    pend = m_flag & m_ctrl[0];
    return m_ctrl[1] ? pend : ~pend;
  endfunction

  function automatic string rd_tag(input logic [1:0] a);
    case (a)
      2'd0:    return "R7";
      2'd2:    return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle; entered and left at posedge+1
  task automatic cyc(input logic we, input logic re, input logic [1:0] a,
                     input logic [7:0] wd, input logic tk);
    logic to;
    reg_we_i = we; reg_re_i = re; reg_addr_i = a; reg_wdata_i = wd; tick_i = tk;
    #2;
    last_rd = reg_rdata_o;
    if (re) chk(reg_rdata_o, exp_read(a), rd_tag(a));
    @(posedge clk_i);
    to = 1'b0;
    if (we && a == 2'd2) begin
      m_cnt = wd[5:0];
    end else if (tk && m_cnt != 0) begin
      if (m_cnt == 6'd1) begin
        to = 1'b1;
        m_cnt = m_rel;
      end else begin
        m_cnt = m_cnt - 6'd1;
      end
    end
    m_rstp = to & m_ctrl[2];
    if (to) m_flag = 1'b1;
    else if (re && a == 2'd0) m_flag = 1'b0;
    if (we && a == 2'd2) m_rel = wd[5:0];
    if (we && a == 2'd1) m_ctrl = wd[2:0];
    #1;
    chk({7'd0, irq_o}, {7'd0, exp_irq()}, "R9");
    chk({7'd0, rst_req_o}, {7'd0, m_rstp}, "R10");
    reg_we_i = 1'b0; reg_re_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic idle();   cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b0); endtask
  task automatic tick();   cyc(1'b0, 1'b0, 2'd0, 8'd0, 1'b1); endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d); cyc(1'b1, 1'b0, a, d, 1'b0); endtask
  task automatic rd(input logic [1:0] a); cyc(1'b0, 1'b1, a, 8'd0, 1'b0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    chk({7'd0, irq_o}, 8'd1, "R1 irq");
    chk({7'd0, rst_req_o}, 8'd0, "R1 rst_req");
    rd(2'd0); chk(last_rd, 8'h00, "R1 flags");
    rd(2'd1); chk(last_rd, 8'h00, "R1 ctrl");
    rd(2'd2); chk(last_rd, 8'h00, "R1 reload");

    // R2 / R11 readback
    wr(2'd2, 8'hEA); rd(2'd2); chk(last_rd, 8'h2A, "R2 readback");
    wr(2'd1, 8'hFF); rd(2'd1); chk(last_rd, 8'h07, "R11 ctrl readback");
    wr(2'd3, 8'h5C); rd(2'd3); chk(last_rd, 8'h00, "R11 spare");
    rd(2'd2); chk(last_rd, 8'h2A, "R11 spare write no effect");

    // R3 exact count, R10 pulse (ctrl: rst_en, active high, irq_en)
    wr(2'd2, 8'd3);
    tick(); tick();
    chk({7'd0, irq_o}, 8'd0, "R3 not early");
    tick();
    chk({7'd0, irq_o}, 8'd1, "R3 timeout");
    chk({7'd0, rst_req_o}, 8'd1, "R10 pulse");
    idle();
    chk({7'd0, rst_req_o}, 8'd0, "R10 one cycle");

    // R7 read clear, R4 restart
    rd(2'd0); chk(last_rd, 8'h80, "R7 flag bit");
    chk({7'd0, irq_o}, 8'd0, "R7 cleared");
    tick(); tick();
    chk({7'd0, irq_o}, 8'd0, "R4 not early");
    tick();
    chk({7'd0, irq_o}, 8'd1, "R4 second period");

    // R5 write during tick restarts
    rd(2'd0);
    tick(); tick();
    cyc(1'b1, 1'b0, 2'd2, 8'd3, 1'b1);
    chk({7'd0, irq_o}, 8'd0, "R5 write wins");
    tick(); tick();
    chk({7'd0, irq_o}, 8'd0, "R5 restarted");
    tick();
    chk({7'd0, irq_o}, 8'd1, "R5 timeout after restart");

    // R8 set beats read clear
    rd(2'd0);
    wr(2'd2, 8'd1);
    cyc(1'b0, 1'b1, 2'd0, 8'd0, 1'b1);
    chk(last_rd, 8'h00, "R8 read before set");
    chk({7'd0, irq_o}, 8'd1, "R8 flag kept");
    rd(2'd0); chk(last_rd, 8'h80, "R8 flag visible");

    // R6 disabled
    wr(2'd2, 8'd0);
    rd(2'd0);
    for (int i = 0; i < 80; i++) tick();
    chk({7'd0, irq_o}, 8'd0, "R6 no timeout");
    rd(2'd0); chk(last_rd, 8'h00, "R6 flag clear");

    // R9 polarity and enable
    wr(2'd2, 8'd1); tick();
    wr(2'd1, 8'd1);
    chk({7'd0, irq_o}, 8'd0, "R9 active low");
    wr(2'd1, 8'd0);
    chk({7'd0, irq_o}, 8'd1, "R9 disabled low-pol");
    wr(2'd1, 8'd2);
    chk({7'd0, irq_o}, 8'd0, "R9 disabled high-pol");
    wr(2'd1, 8'd3);
    chk({7'd0, irq_o}, 8'd1, "R9 active high");
    rd(2'd0);
    chk({7'd0, irq_o}, 8'd0, "R9 released");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic       we, re, tk;
      logic [1:0] a;
      logic [7:0] wd;
      we = ($urandom % 16) == 0;
      re = ($urandom % 6) == 0;
      tk = ($urandom % 2) == 0;
      a  = 2'($urandom % 4);
      wd = 8'($urandom);
      if (we && a == 2'd2 && ($urandom % 4) != 0) wd = wd & 8'h07;
      cyc(we, re, a, wd, tk);
    end

    finish_run();
  end
endmodule